// File: doc/BRIEF.md
# Output-Stationary Systolic Multiply-Accumulate Grid

This block is a square grid of multiply-accumulate cells for integer matrix products. Each cell owns one element of the result and keeps it in place. Operands from the left-hand matrix flow rightwards through the grid and operands from the right-hand matrix flow downwards. On every cycle that carries data, the caller presents one column of A (one byte per grid row) and the matching row of B (one byte per grid column), with a single valid strobe.

Edge skew lines delay the lane of grid row `r` by `r` cycles and the lane of grid column `c` by `c` cycles. As a result, `A[m][k]` and `B[k][n]` meet in cell `(m,n)` on the same clock edge. A reduction of any length K fills the grid with a 4x4 block of `C = A·B`.

A clear strobe zeroes every sum in one cycle. The sums are read in parallel from one wide output bus. Memory addressing, tiling and write-back belong to the surrounding logic.

Top module: `os_mac_grid`

## Requirements
- R1: While reset is asserted and after it is released, every sum on `sums_o` is zero until a product or clear changes it; all state uses an asynchronous active-low reset.
- R2: After a clear, K valid cycles carrying column k of A and row k of B, and six further cycles, the field of cell `(m,n)` equals the sum over k of `A[m][k]*B[k][n]`, for any K including 1.
- R3: Operands are signed two's complement bytes and are sign-extended before the multiply. The 32-bit sum wraps modulo 2^32.
- R4: Lane i of `a_col_i` occupies bits `[8*i +: 8]` and carries A for grid row i. Lane j of `b_row_i` occupies bits `[8*j +: 8]` and carries B for grid column j. Cell `(m,n)` drives `sums_o[32*(4*m+n) +: 32]`.
- R5: A pair presented on the clock edge at which `vld_i` is sampled high is added into cell `(m,n)` exactly `m+n` edges later. Cell (0,0) adds it at that same edge.
- R6: Cycles with `vld_i` low add nothing, whatever the operand lanes carry, and idle cycles may be placed between reduction steps.
- R7: A clear sampled on an edge makes every sum zero after that edge. An operand pair that would have been added at that same edge is discarded. Pairs still in flight are added at their later edges as usual.
- R8: Without a clear, a new pass adds onto the sums left by the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Zero all sums on this edge |
| vld_i | input | 1 | Operand lanes carry a reduction step |
| a_col_i | input | 32 | One signed byte of A per grid row |
| b_row_i | input | 32 | One signed byte of B per grid column |
| sums_o | output | 512 | Sixteen 32-bit signed sums, cell (m,n) at index 4m+n |

## Verification
On every cycle, the assertions check the zero state under reset, the zeroing after a clear, and the exact signed update of the corner cell (0,0). They also check that all sums hold still once the grid has been idle longer than its deepest skew path.

Only the bench can show behaviour that involves the skew. This covers the `m+n` edge arrival time of every other cell, the dropped products when a clear meets data in flight, and full products for several K values with gaps. A cycle-by-cycle model of arrival times compares all sixteen sums on each clock, and direct matrix products are compared at the end of each pass.

// File: rtl/mac_grid_pkg.sv
package mac_grid_pkg;
    localparam int unsigned OP_W  = 8;
    localparam int unsigned ACC_W = 32;

    typedef logic signed [OP_W-1:0]  op_t;
    typedef logic signed [ACC_W-1:0] acc_t;

    typedef struct packed {
        logic v;
        op_t  d;
    } lane_t;
endpackage

// File: rtl/mac_skew_lane.sv
module mac_skew_lane
    import mac_grid_pkg::*;
#(
    parameter int unsigned DELAY = 0
) (
    input  logic  clk,
    input  logic  rst_n,
    input  lane_t in_i,
    output lane_t out_o
);
    generate
        if (DELAY == 0) begin : g_pass
            assign out_o = in_i;
        end else begin : g_dly
            typedef struct packed {
                lane_t [DELAY-1:0] stg;
            } skew_st_t;

            skew_st_t st_d, st_q;

            always_comb begin
                st_d        = st_q;
                st_d.stg[0] = in_i;
                for (int i = 1; i < int'(DELAY); i++) begin
                    st_d.stg[i] = st_q.stg[i-1];
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) st_q <= '0;
                else        st_q <= st_d;
            end

            assign out_o = st_q.stg[DELAY-1];
        end
    endgenerate
endmodule

// File: rtl/mac_cell.sv
module mac_cell
    import mac_grid_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clr_i,
    input  lane_t a_i,
    input  lane_t b_i,
    output lane_t a_o,
    output lane_t b_o,
    output acc_t  acc_o
);
    typedef struct packed {
        lane_t a;
        lane_t b;
        acc_t  acc;
    } cell_st_t;

    cell_st_t st_d, st_q;
    acc_t     prod;

    always_comb begin
        prod   = acc_t'(a_i.d) * acc_t'(b_i.d);
        st_d   = st_q;
        st_d.a = a_i;
        st_d.b = b_i;
        if (clr_i) begin
            st_d.acc = '0;
        end else if (a_i.v && b_i.v) begin
            st_d.acc = st_q.acc + prod;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign a_o   = st_q.a;
    assign b_o   = st_q.b;
    assign acc_o = st_q.acc;
endmodule

// File: rtl/os_mac_grid.sv
module os_mac_grid
    import mac_grid_pkg::*;
#(
    parameter int unsigned ROWS = 4,
    parameter int unsigned COLS = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clr_i,
    input  logic                        vld_i,
    input  logic [ROWS*OP_W-1:0]        a_col_i,
    input  logic [COLS*OP_W-1:0]        b_row_i,
    output logic [ROWS*COLS*ACC_W-1:0]  sums_o
);
    lane_t a_w [ROWS][COLS+1];
    lane_t b_w [ROWS+1][COLS];

    genvar r, c;
    generate
        for (r = 0; r < ROWS; r++) begin : g_rskew
            lane_t lane_in;
            assign lane_in.v = vld_i;
            assign lane_in.d = op_t'(a_col_i[r*OP_W +: OP_W]);
            mac_skew_lane #(.DELAY(r)) u_skew (
                .clk   (clk),
                .rst_n (rst_n),
                .in_i  (lane_in),
                .out_o (a_w[r][0])
            );
        end

        for (c = 0; c < COLS; c++) begin : g_cskew
            lane_t lane_in;
            assign lane_in.v = vld_i;
            assign lane_in.d = op_t'(b_row_i[c*OP_W +: OP_W]);
            mac_skew_lane #(.DELAY(c)) u_skew (
                .clk   (clk),
                .rst_n (rst_n),
                .in_i  (lane_in),
                .out_o (b_w[0][c])
            );
        end

        for (r = 0; r < ROWS; r++) begin : g_row
            for (c = 0; c < COLS; c++) begin : g_col
                acc_t acc;
                mac_cell u_cell (
                    .clk   (clk),
                    .rst_n (rst_n),
                    .clr_i (clr_i),
                    .a_i   (a_w[r][c]),
                    .b_i   (b_w[r][c]),
                    .a_o   (a_w[r][c+1]),
                    .b_o   (b_w[r+1][c]),
                    .acc_o (acc)
                );
                assign sums_o[(r*COLS+c)*ACC_W +: ACC_W] = acc;
            end
        end
    endgenerate
endmodule

// File: rtl/os_mac_grid_chk.sv
module os_mac_grid_chk #(
    parameter int unsigned ROWS  = 4,
    parameter int unsigned COLS  = 4,
    parameter int unsigned OP_W  = 8,
    parameter int unsigned ACC_W = 32
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       clr_i,
    input logic                       vld_i,
    input logic [OP_W-1:0]            a0_i,
    input logic [OP_W-1:0]            b0_i,
    input logic [ROWS*COLS*ACC_W-1:0] sums_i
);
    localparam int unsigned DRAIN = ROWS + COLS - 2;

    logic signed [ACC_W-1:0] a0x, b0x, p00, s00;
    logic [7:0] idle_q;

    assign a0x = ACC_W'($signed(a0_i));
    assign b0x = ACC_W'($signed(b0_i));
    assign p00 = a0x * b0x;
    assign s00 = sums_i[ACC_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          idle_q <= '0;
        else if (vld_i)      idle_q <= '0;
        else if (idle_q != 8'hFF) idle_q <= idle_q + 8'd1;
    end

    // R1
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_zero_chk: assert (sums_i == '0);
        end
    end

    // R7
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (sums_i == '0));

    // R3
    corner_mac_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && !clr_i) |=> (s00 == $past(s00) + $past(p00)));

    // R6
    corner_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!vld_i && !clr_i) |=> $stable(s00));

    // R6
    drained_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_q >= 8'(DRAIN) && !vld_i && !clr_i) |=> $stable(sums_i));
endmodule

bind os_mac_grid os_mac_grid_chk #(
    .ROWS  (ROWS),
    .COLS  (COLS),
    .OP_W  (mac_grid_pkg::OP_W),
    .ACC_W (mac_grid_pkg::ACC_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (clr_i),
    .vld_i  (vld_i),
    .a0_i   (a_col_i[mac_grid_pkg::OP_W-1:0]),
    .b0_i   (b_row_i[mac_grid_pkg::OP_W-1:0]),
    .sums_i (sums_o)
);

// File: tb/os_mac_grid_test.sv
`timescale 1ns/1ps
module os_mac_grid_test;
    localparam int R = 4, C = 4, W = 8, AW = 32, MAXK = 32, HN = 4096;

    logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0, vld = 1'b0;
    logic [R*W-1:0] a_in = '0;
    logic [C*W-1:0] b_in = '0;
    logic [R*C*AW-1:0] sums;

    always #4 clk = ~clk;

    os_mac_grid uut (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .vld_i(vld),
        .a_col_i(a_in), .b_row_i(b_in), .sums_o(sums)
    );

    int tests = 0, fails = 0;
    int ma [R][MAXK];
    int mb [MAXK][C];
    int exp_c [R][C];
    bit done = 0;

    // behavioural reference: input history plus arrival age m+n
    int ha [HN][R];
    int hb [HN][C];
    bit hv [HN];
    int acc_m [R][C];
    longint t;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t = 0;
            foreach (acc_m[i, j]) acc_m[i][j] = 0;
            foreach (hv[i]) hv[i] = 0;
        end else begin
            int slot;
            slot = int'(t % HN);
            hv[slot] = vld;
            for (int i = 0; i < R; i++) ha[slot][i] = int'($signed(a_in[i*W +: W]));
            for (int j = 0; j < C; j++) hb[slot][j] = int'($signed(b_in[j*W +: W]));
            for (int m = 0; m < R; m++) begin
                for (int n = 0; n < C; n++) begin
                    longint age;
                    age = t - m - n;
                    if (clr) acc_m[m][n] = 0;
                    else if (age >= 0 && hv[int'(age % HN)])
                        acc_m[m][n] = acc_m[m][n] + ha[int'(age % HN)][m] * hb[int'(age % HN)][n];
                end
            end
            t = t + 1;
        end
    end

    function automatic int sum_at(int m, int n);
        return int'($signed(sums[(m*C+n)*AW +: AW]));
    endfunction

    task automatic check(string tag, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // R5: per-cycle timing of each cell against the arrival model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int m = 0; m < R; m++)
                for (int n = 0; n < C; n++)
                    check($sformatf("R5 cell(%0d,%0d) t=%0d", m, n, t), sum_at(m, n), acc_m[m][n]);
        end
    end

    function automatic int rnd8();
        return int'($signed(8'($urandom)));
    endfunction

    task automatic idle_drive();
        vld  = 1'b0;
        a_in = R*W'($urandom);
        b_in = C*W'($urandom);
    endtask

    task automatic load_step(int k);
        vld = 1'b1;
        for (int i = 0; i < R; i++) a_in[i*W +: W] = 8'(ma[i][k]);
        for (int j = 0; j < C; j++) b_in[j*W +: W] = 8'(mb[k][j]);
    endtask

    task automatic do_clear();
        @(negedge clk); idle_drive(); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        foreach (exp_c[i, j]) exp_c[i][j] = 0;
    endtask

    task automatic run_pass(int K, int gap, string tag);
        for (int k = 0; k < K; k++) begin
            @(negedge clk); load_step(k);
            for (int i = 0; i < R; i++)
                for (int j = 0; j < C; j++)
                    exp_c[i][j] = exp_c[i][j] + ma[i][k] * mb[k][j];
            if (gap > 0 && (k % 2 == 1))
                repeat (gap) begin @(negedge clk); idle_drive(); end
        end
        @(negedge clk); idle_drive();
        repeat (6) @(negedge clk);
        for (int m = 0; m < R; m++)
            for (int n = 0; n < C; n++)
                check($sformatf("%s K=%0d C[%0d][%0d]", tag, K, m, n), sum_at(m, n), exp_c[m][n]);
    endtask

    task automatic fill_rand(int K);
        for (int k = 0; k < K; k++) begin
            for (int i = 0; i < R; i++) ma[i][k] = rnd8();
            for (int j = 0; j < C; j++) mb[k][j] = rnd8();
        end
    endtask

    initial begin
        #(8.0 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: zero under reset
        for (int m = 0; m < R; m++)
            for (int n = 0; n < C; n++)
                check("R1 in reset", sum_at(m, n), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        for (int m = 0; m < R; m++)
            for (int n = 0; n < C; n++)
                check("R1 after release", sum_at(m, n), 0);

        // R2 R4: square product
        do_clear(); fill_rand(4); run_pass(4, 0, "R2 R4 square");
        // R2: single step
        do_clear(); fill_rand(1); run_pass(1, 0, "R2 single");
        // R6: long reduction with idle gaps carrying junk data
        do_clear(); fill_rand(16); run_pass(16, 3, "R6 gaps");
        // R3: signed extremes
        do_clear();
        for (int k = 0; k < 20; k++) begin
            for (int i = 0; i < R; i++) ma[i][k] = (i % 2 == 0) ? -128 : 127;
            for (int j = 0; j < C; j++) mb[k][j] = (j < 2) ? -128 : -1;
        end
        run_pass(20, 0, "R3 signed");
        // R8: accumulate across passes without clear
        fill_rand(7); run_pass(7, 1, "R8 carry-on");

        // R7: clear meets a step in flight
        do_clear(); fill_rand(6);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk); load_step(k); clr = (k == 3);
        end
        @(negedge clk); idle_drive(); clr = 1'b0;
        repeat (6) @(negedge clk);
        for (int m = 0; m < R; m++)
            for (int n = 0; n < C; n++) begin
                int e;
                e = 0;
                for (int k = 0; k < 6; k++)
                    if (k + m + n > 3) e = e + ma[m][k] * mb[k][n];
                check($sformatf("R7 midflight C[%0d][%0d]", m, n), sum_at(m, n), e);
            end

        // R6: long idle with junk, sums hold
        for (int m = 0; m < R; m++)
            for (int n = 0; n < C; n++) exp_c[m][n] = sum_at(m, n);
        repeat (10) begin @(negedge clk); idle_drive(); end
        for (int m = 0; m < R; m++)
            for (int n = 0; n < C; n++)
                check("R6 idle hold", sum_at(m, n), exp_c[m][n]);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule